// File: doc/BRIEF.md
# SDRAM Idle Low-Power Entry Controller

This block watches the access-request line of an SDRAM controller and counts consecutive cycles with no request. When the count reaches the timeout of the selected low-power mode, it emits a one-cycle entry strobe for clock stop, self-refresh or power-down, and reports the state it has entered. The command sequencer next to it turns each strobe into real SDRAM commands. A 3-bit mode field picks the mode. Each mode has its own 4-bit timeout code, and the code sets the idle window as a power of two.

When a request arrives while the device is in a low-power state, the block emits an exit strobe and keeps the request ungranted until the sequencer reports that the exit is done. Leaving power-down adds one more step: a long impedance calibration request that holds off all traffic until it completes. While a frequency change is being requested, entry into self-refresh is held back. A build parameter removes clock-stop support, and in that build the clock-stop timeout code is read as zero.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset all entry and exit strobes, `calReq` and `lpState` are 0, and the block is in the active state.
- R2: `modeSel` selects 0 = disabled, 1 = clock stop, 2 = self-refresh, 4 = power-down. Any other value behaves as disabled, and no entry ever occurs. `lpState` reports 0 = active, 1 = clock stop, 2 = self-refresh, 3 = power-down.
- R3: A timeout code n sets a window of 2^(n+3) cycles. The entry strobe of the selected mode is high for exactly one cycle, in the cycle after the edge that samples `accReq` low for the 2^(n+3)-th consecutive time.
- R4: In self-refresh mode, a timeout code below 6 is used as 6.
- R5: Only the timeout field of the selected mode affects the entry time. The other two fields have no effect.
- R6: Any cycle with `accReq` high while active restarts the idle count from zero.
- R7: While `freqChgReq` is high and the mode is self-refresh, entry is suppressed. Once the request drops, entry follows on the next edge if the idle window has already elapsed. The other modes are not affected by `freqChgReq`.
- R8: `accReq` high in a low-power state gives a one-cycle exit strobe for that state. `accGrant` stays low and `lpState` holds the state until `exitDone` is sampled high.
- R9: After a power-down exit completes, `calReq` stays high, with `accGrant` low and `lpState` 0, until `calDone` is sampled high. The block then returns to active.
- R10: With `HAS_CLK_STOP` = 0, the clock-stop timeout field is treated as code 0, which gives an 8-cycle window.
- R11: In the active state, `accGrant` equals `accReq`. In every other state it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Low-power mode select |
| tmoClkStop | input | TMO_W | Clock-stop timeout code |
| tmoSelfRef | input | TMO_W | Self-refresh timeout code |
| tmoPwrDn | input | TMO_W | Power-down timeout code |
| accReq | input | 1 | Access request from the command side |
| freqChgReq | input | 1 | Frequency change in progress |
| exitDone | input | 1 | Sequencer finished the low-power exit |
| calDone | input | 1 | Long calibration finished |
| accGrant | output | 1 | Access may proceed |
| csEnter | output | 1 | Clock-stop entry strobe |
| srEnter | output | 1 | Self-refresh entry strobe |
| pdEnter | output | 1 | Power-down entry strobe |
| csExit | output | 1 | Clock-stop exit strobe |
| srExit | output | 1 | Self-refresh exit strobe |
| pdExit | output | 1 | Power-down exit strobe |
| calReq | output | 1 | Long calibration request after power-down exit |
| lpState | output | 2 | Current low-power state indicator |

## Verification
The bench sweeps timeout codes in each mode and counts the exact number of idle edges before entry. An off-by-one in the counter or the shift shows up as an entry one cycle early or late, or at double or half the window. Self-refresh codes below 6 must all give the same 512-cycle window, so a missing clamp enters far too early. The unused timeout fields are set to unrelated values, so a decoder that reads the wrong field gives wrong counts. Further tests drop a request into a partially elapsed window, hold `freqChgReq` high past the window, and leave power-down. These catch a counter that does not restart, an entry that slips through or is lost during a frequency change, and a grant issued before the calibration has finished.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_CS  = 3'd1;
  localparam logic [2:0] MODE_SR  = 3'd2;
  localparam logic [2:0] MODE_PD  = 3'd4;
  localparam int unsigned SR_MIN_CODE = 6;

  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_CS   = 2'd1;
  localparam logic [1:0] KIND_SR   = 2'd2;
  localparam logic [1:0] KIND_PD   = 2'd3;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_LOWPWR = 2'd1,
    ST_WAKE   = 2'd2,
    ST_CALIB  = 2'd3
  } lpc_state_e;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
  } lpc_ctl_t;
endpackage

// File: rtl/lpc_datapath.sv
module lpc_datapath
  import lpc_pkg::*;
#(
  parameter int TMO_W = 4,
  parameter bit HAS_CLK_STOP = 1'b1,
  localparam int CNT_W = (1 << TMO_W) + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic [TMO_W-1:0] tmoClkStop,
  input  logic [TMO_W-1:0] tmoSelfRef,
  input  logic [TMO_W-1:0] tmoPwrDn,
  input  lpc_ctl_t         ctl,
  output logic             idleHit
);
  logic [TMO_W-1:0] csCode;
  logic [TMO_W-1:0] effCode;
  logic [TMO_W:0]   shiftAmt;
  logic [CNT_W-1:0] limitM1;
  logic [CNT_W-1:0] idleCnt;

  generate
    if (HAS_CLK_STOP) begin : g_cs
      assign csCode = tmoClkStop;
    end else begin : g_nocs
      assign csCode = '0;
    end
  endgenerate

  always_comb begin
    case (modeSel)
      MODE_CS: effCode = csCode;
      MODE_SR: effCode = (tmoSelfRef < TMO_W'(SR_MIN_CODE)) ? TMO_W'(SR_MIN_CODE) : tmoSelfRef;
      MODE_PD: effCode = tmoPwrDn;
      default: effCode = '0;
    endcase
    shiftAmt = {1'b0, effCode} + (TMO_W+1)'(3);
    limitM1  = (CNT_W'(1) << shiftAmt) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) begin
      idleCnt <= '0;
    end else if (ctl.cntRun && (idleCnt < limitM1)) begin
      idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  assign idleHit = (idleCnt >= limitM1);
endmodule

// File: rtl/lpc_control.sv
module lpc_control
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       accReq,
  input  logic       freqChgReq,
  input  logic       exitDone,
  input  logic       calDone,
  input  logic       idleHit,
  output lpc_ctl_t   ctl,
  output logic       accGrant,
  output logic [2:0] enterStb,
  output logic [2:0] exitStb,
  output logic       calReq,
  output logic [1:0] lpState
);
  lpc_state_e state;
  logic [1:0] lpKind;
  logic       modeValid;
  logic       inhibit;
  logic       doEnter;
  logic [1:0] newKind;

  always_comb begin
    case (modeSel)
      MODE_CS: newKind = KIND_CS;
      MODE_SR: newKind = KIND_SR;
      MODE_PD: newKind = KIND_PD;
      default: newKind = KIND_NONE;
    endcase
    modeValid = (newKind != KIND_NONE);
    inhibit   = freqChgReq && (modeSel == MODE_SR);
    doEnter   = (state == ST_ACTIVE) && !accReq && idleHit && modeValid && !inhibit;
    ctl.cntClr = (state != ST_ACTIVE) || accReq;
    ctl.cntRun = (state == ST_ACTIVE) && !accReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_ACTIVE;
      lpKind   <= KIND_NONE;
      enterStb <= '0;
      exitStb  <= '0;
    end else begin
      enterStb <= '0;
      exitStb  <= '0;
      case (state)
        ST_ACTIVE: if (doEnter) begin
          state  <= ST_LOWPWR;
          lpKind <= newKind;
          enterStb[newKind - 2'd1] <= 1'b1;
        end
        ST_LOWPWR: if (accReq) begin
          state <= ST_WAKE;
          exitStb[lpKind - 2'd1] <= 1'b1;
        end
        ST_WAKE: if (exitDone) begin
          state  <= (lpKind == KIND_PD) ? ST_CALIB : ST_ACTIVE;
          lpKind <= KIND_NONE;
        end
        ST_CALIB: if (calDone) state <= ST_ACTIVE;
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  assign accGrant = (state == ST_ACTIVE) && accReq;
  assign calReq   = (state == ST_CALIB);
  assign lpState  = lpKind;
endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl
  import lpc_pkg::*;
#(
  parameter int TMO_W = 4,
  parameter bit HAS_CLK_STOP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic [TMO_W-1:0] tmoClkStop,
  input  logic [TMO_W-1:0] tmoSelfRef,
  input  logic [TMO_W-1:0] tmoPwrDn,
  input  logic             accReq,
  input  logic             freqChgReq,
  input  logic             exitDone,
  input  logic             calDone,
  output logic             accGrant,
  output logic             csEnter,
  output logic             srEnter,
  output logic             pdEnter,
  output logic             csExit,
  output logic             srExit,
  output logic             pdExit,
  output logic             calReq,
  output logic [1:0]       lpState
);
  lpc_ctl_t   ctl;
  logic       idleHit;
  logic [2:0] enterStb;
  logic [2:0] exitStb;

  lpc_datapath #(.TMO_W(TMO_W), .HAS_CLK_STOP(HAS_CLK_STOP)) u_dp (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .tmoClkStop(tmoClkStop), .tmoSelfRef(tmoSelfRef), .tmoPwrDn(tmoPwrDn),
    .ctl(ctl), .idleHit(idleHit)
  );

  lpc_control u_ctl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .accReq(accReq),
    .freqChgReq(freqChgReq), .exitDone(exitDone), .calDone(calDone),
    .idleHit(idleHit), .ctl(ctl), .accGrant(accGrant),
    .enterStb(enterStb), .exitStb(exitStb), .calReq(calReq), .lpState(lpState)
  );

  assign {pdEnter, srEnter, csEnter} = enterStb;
  assign {pdExit, srExit, csExit}    = exitStb;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       accReq,
  input logic       freqChgReq,
  input logic       calDone,
  input logic       accGrant,
  input logic       csEnter,
  input logic       srEnter,
  input logic       pdEnter,
  input logic       csExit,
  input logic       srExit,
  input logic       pdExit,
  input logic       calReq,
  input logic [1:0] lpState
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({csEnter, srEnter, pdEnter, csExit, srExit, pdExit})); // R3
  AST_ENTER_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (csEnter || srEnter || pdEnter) |-> ($past(lpState) == 2'd0 && !$past(calReq))); // R2
  AST_NO_SR_IN_FREQ_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    srEnter |-> !$past(freqChgReq)); // R7
  AST_EXIT_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (csExit || srExit || pdExit) |-> $past(accReq)); // R8
  AST_GRANT_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (lpState == 2'd0 && !calReq && accReq)); // R11
  AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (calReq && !calDone) |=> calReq); // R9
endmodule

bind lp_idle_ctrl lpc_checker u_chk (.*);

// File: tb/sim_lp_idle_ctrl.sv
module sim_lp_idle_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [3:0] tmoClkStop = 4'd0, tmoSelfRef = 4'd0, tmoPwrDn = 4'd0;
  logic accReq = 1'b0, freqChgReq = 1'b0, exitDone = 1'b0, calDone = 1'b0;
  logic gr0, ce0, se0, pe0, cx0, sx0, px0, cal0;
  logic gr1, ce1, se1, pe1, cx1, sx1, px1, cal1;
  logic [1:0] lp0, lp1;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lp_idle_ctrl #(.TMO_W(4), .HAS_CLK_STOP(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .tmoClkStop(tmoClkStop),
    .tmoSelfRef(tmoSelfRef), .tmoPwrDn(tmoPwrDn), .accReq(accReq),
    .freqChgReq(freqChgReq), .exitDone(exitDone), .calDone(calDone),
    .accGrant(gr0), .csEnter(ce0), .srEnter(se0), .pdEnter(pe0),
    .csExit(cx0), .srExit(sx0), .pdExit(px0), .calReq(cal0), .lpState(lp0));

  lp_idle_ctrl #(.TMO_W(4), .HAS_CLK_STOP(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .tmoClkStop(tmoClkStop),
    .tmoSelfRef(tmoSelfRef), .tmoPwrDn(tmoPwrDn), .accReq(accReq),
    .freqChgReq(freqChgReq), .exitDone(exitDone), .calDone(calDone),
    .accGrant(gr1), .csEnter(ce1), .srEnter(se1), .pdEnter(pe1),
    .csExit(cx1), .srExit(sx1), .pdExit(px1), .calReq(cal1), .lpState(lp1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] enterOf(input int inst);
    return inst == 1 ? {pe1, se1, ce1} : {pe0, se0, ce0};
  endfunction
  function automatic logic [2:0] exitOf(input int inst);
    return inst == 1 ? {px1, sx1, cx1} : {px0, sx0, cx0};
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    accReq = 1'b1; exitDone = 1'b1; calDone = 1'b1;
    repeat (3) cyc();
    exitDone = 1'b0; calDone = 1'b0; freqChgReq = 1'b0;
  endtask

  function automatic int kindOf(input int mode);
    return mode == 1 ? 1 : mode == 2 ? 2 : 3;
  endfunction

  // R3 R4 R5 R6 R8 R9 R10 R11
  task automatic measure(input int inst, input int mode, input int code, input int preIdle,
                         input bit freq, input string tag);
    int eff, expCnt, k, kind;
    logic [2:0] en, ex;
    settle();
    modeSel = 3'(mode);
    tmoClkStop = 4'(15 - code); tmoSelfRef = 4'(14 - code); tmoPwrDn = 4'(13 - code);
    if (mode == 1) tmoClkStop = 4'(code);
    if (mode == 2) tmoSelfRef = 4'(code);
    if (mode == 4) tmoPwrDn = 4'(code);
    freqChgReq = freq;
    cyc();
    chk((inst == 1 ? gr1 : gr0) == 1'b1, "R11 grant while active", int'(inst == 1 ? gr1 : gr0), 1);
    kind = kindOf(mode);
    eff = code;
    if (mode == 2 && code < 6) eff = 6;
    if (mode == 1 && inst == 1) eff = 0;
    expCnt = 1 << (eff + 3);
    if (preIdle > 0) begin
      accReq = 1'b0;
      repeat (preIdle) cyc();
      accReq = 1'b1;
      cyc();
    end
    accReq = 1'b0;
    k = 0;
    en = 3'b000;
    while (k < 2 * expCnt + 20) begin
      cyc();
      k++;
      en = enterOf(inst);
      if (en != 3'b000) break;
    end
    chk(k == expCnt, tag, k, expCnt);
    chk(en == 3'(1 << (kind - 1)), "R2 entry strobe kind", int'(en), 1 << (kind - 1));
    chk(int'(inst == 1 ? lp1 : lp0) == kind, "R2 lpState code", int'(inst == 1 ? lp1 : lp0), kind);
    cyc();
    chk(enterOf(inst) == 3'b000, "R3 strobe one cycle", int'(enterOf(inst)), 0);
    accReq = 1'b1;
    chk((inst == 1 ? gr1 : gr0) == 1'b0, "R8 no grant in low power", 1, 0);
    cyc();
    ex = exitOf(inst);
    chk(ex == 3'(1 << (kind - 1)), "R8 exit strobe", int'(ex), 1 << (kind - 1));
    cyc();
    chk(exitOf(inst) == 3'b000 && (inst == 1 ? gr1 : gr0) == 1'b0 &&
        int'(inst == 1 ? lp1 : lp0) == kind, "R8 held until exitDone", int'(inst == 1 ? gr1 : gr0), 0);
    exitDone = 1'b1;
    cyc();
    exitDone = 1'b0;
    if (kind == 3) begin
      repeat (3) begin
        chk((inst == 1 ? cal1 : cal0) == 1'b1 && (inst == 1 ? gr1 : gr0) == 1'b0 &&
            (inst == 1 ? lp1 : lp0) == 2'd0, "R9 calibration holds access", int'(inst == 1 ? cal1 : cal0), 1);
        cyc();
      end
      calDone = 1'b1;
      cyc();
      calDone = 1'b0;
    end
    chk((inst == 1 ? gr1 : gr0) == 1'b1 && (inst == 1 ? cal1 : cal0) == 1'b0, "R8 R9 grant after wake",
        int'(inst == 1 ? gr1 : gr0), 1);
  endtask

  // R2 R7
  task automatic noEntry(input int mode, input int cycles, input bit freq, input string tag);
    bit seen;
    settle();
    modeSel = 3'(mode);
    tmoClkStop = 4'd0; tmoSelfRef = 4'd0; tmoPwrDn = 4'd0;
    freqChgReq = freq;
    accReq = 1'b0;
    seen = 1'b0;
    repeat (cycles) begin
      cyc();
      if (enterOf(0) != 3'b000) seen = 1'b1;
    end
    chk(!seen && lp0 == 2'd0, tag, int'(seen), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({ce0, se0, pe0, cx0, sx0, px0, cal0} == 7'd0 && lp0 == 2'd0, "R1 reset state", int'(lp0), 0);
    rstN = 1'b1;
    cyc();
    chk({ce0, se0, pe0, cx0, sx0, px0, cal0} == 7'd0 && lp0 == 2'd0, "R1 after reset", int'(lp0), 0);
    for (int c = 0; c < 8; c++) measure(0, 1, c, 0, 1'b0, "R3 R5 clock-stop window");
    for (int c = 0; c < 8; c++) measure(0, 4, c, 0, 1'b0, "R3 R5 power-down window");
    for (int c = 0; c < 9; c++) measure(0, 2, c, 0, 1'b0, "R4 self-refresh window");
    for (int c = 0; c < 4; c++) measure(1, 1, c, 0, 1'b0, "R10 no clock-stop variant window");
    measure(0, 1, 2, 20, 1'b0, "R6 access restarts count");
    measure(0, 4, 1, 10, 1'b0, "R6 restart in power-down");
    measure(0, 4, 0, 0, 1'b1, "R7 freq change ignored for power-down");
    measure(0, 1, 0, 0, 1'b1, "R7 freq change ignored for clock stop");
    for (int m = 0; m < 8; m++) begin
      if (m != 1 && m != 2 && m != 4) noEntry(m, 300, 1'b0, "R2 disabled or reserved mode");
    end
    noEntry(2, 1000, 1'b1, "R7 self-refresh held during freq change");
    freqChgReq = 1'b0;
    cyc();
    chk(se0 == 1'b1 && lp0 == 2'd2, "R7 entry after freq change ends", int'(se0), 1);
    settle();
    chk(lp0 == 2'd0 && gr0 == 1'b1, "R8 back to active", int'(lp0), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule